// File: doc/BRIEF.md
# Serial Port Register Bank with Interrupt Identification

This block is the software-facing register file of a byte-wide serial port. It decodes eight byte addresses, keeps the interrupt enable, line setup and modem control registers, and holds a 16-bit baud divisor. The divisor shares addresses 0 and 1 with the data port and the interrupt enable register. A bit in the line setup register selects which of the two the bus reaches. The serial core drives four condition inputs. The bank turns them into a prioritised identity code that software can read, and into one interrupt pin that a modem control bit can mask.

The serial core receives the configuration as plain outputs: word length, stop bits, parity mode and divisor. A data byte written to address 0 appears on `tx_data` together with a one-cycle `tx_valid` strobe. A read of address 0 returns `rx_data` and pulses `rx_pop` in the same cycle. These strobes are single-beat transfers and carry no back-pressure, because the core's holding register captures them on the cycle they occur. `tx_empty` is the core's way to show when it can take the next byte.

Top module: `uart_reg_bank`

## Requirements
- R1: After reset all stored registers read zero, address 2 reads 0x01, and `irq`, `dtr`, `rts` and `divisor` are all zero.
- R2: Reads return the following. Address 1 gives the enable nibble in bits 3:0. Address 2 gives the identity. Address 3 gives the line setup byte. Address 4 gives modem control bits 4:0. Addresses 5 and 6 pass `line_stat` and `modem_stat` through. Address 7 reads zero.
- R3: While line setup bit 7 is 1, addresses 0 and 1 read and write the divisor low and high bytes, and `tx_valid` and `rx_pop` stay low. The enable register is left unchanged.
- R4: While line setup bit 7 is 0, a write to address 0 raises `tx_valid` with `tx_data` equal to the written byte in that same cycle. A read of address 0 returns `rx_data` and raises `rx_pop` in that same cycle.
- R5: `word_len` equals line setup bits 1:0, which hold data bits minus 5. `two_stop` equals bit 2. `parity_sel` equals bits 5:3, with these codes: 000 none, 001 odd, 011 even, 101 forced mark, 111 forced space.
- R6: Identity bit 0 is 1 when no enabled source is pending. Otherwise bits 2:1 name the source: 11 line error, 10 receive data, 01 transmit empty, 00 modem change. Bits 5:3 read zero.
- R7: The enable bits are bit 0 receive data, bit 1 transmit empty, bit 2 line error and bit 3 modem change. When several enabled sources are pending, the identity reports the first of this order: line error, receive data, transmit empty, modem change.
- R8: Writing address 2 with bit 0 set makes identity bits 7:6 read 11. Writing it with bit 0 clear makes them read 00.
- R9: A rising edge of `tx_empty` makes the transmit-empty condition pending. Two things clear it: a read of the identity while it reports transmit empty, and a write of the data byte.
- R10: `irq` is 1 exactly one cycle after any enabled source is pending while modem control bit 3 is set. Otherwise it is 0.
- R11: `dtr` follows modem control bit 0 and `rts` follows bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (triggers read side effects) |
| rdata | output | 8 | Read data, combinational on addr |
| rx_data | input | 8 | Received byte from the core |
| line_stat | input | 8 | Line status byte from the core |
| modem_stat | input | 8 | Modem status byte from the core |
| line_err | input | 1 | Receive line error condition |
| rx_avail | input | 1 | Receive data available condition |
| tx_empty | input | 1 | Transmit holding register empty |
| modem_chg | input | 1 | Modem status change condition |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | One-cycle strobe for tx_data |
| rx_pop | output | 1 | One-cycle strobe consuming rx_data |
| word_len | output | 2 | Data bits minus 5 |
| two_stop | output | 1 | Two stop bits selected |
| parity_sel | output | 3 | Parity mode code |
| divisor | output | 16 | Baud divisor |
| fifo_en | output | 1 | FIFO mode enabled |
| dtr | output | 1 | Data terminal ready |
| rts | output | 1 | Request to send |
| irq | output | 1 | Interrupt output |

## Verification
Read data, `tx_valid`, `tx_data` and `rx_pop` are combinational, so the bench samples them in the middle of the strobe cycle. Register contents, the configuration outputs and the transmit-empty pending state change at the clock edge that ends a write or an edge of `tx_empty`. The bench checks them on the falling edge after that. `irq` has one more register stage, so it is checked one full cycle after its conditions settle. The identity sweep arms the transmit-empty source with a low-then-high `tx_empty` pair of cycles and then waits that extra cycle before it compares the pin.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] A_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_IDENT = 3'd2;
  localparam logic [ADDR_W-1:0] A_LINE  = 3'd3;
  localparam logic [ADDR_W-1:0] A_MODEM = 3'd4;
  localparam logic [ADDR_W-1:0] A_LSTAT = 3'd5;
  localparam logic [ADDR_W-1:0] A_MSTAT = 3'd6;

  typedef enum logic [1:0] {
    SRC_MODEM = 2'b00,
    SRC_TXE   = 2'b01,
    SRC_RXD   = 2'b10,
    SRC_LERR  = 2'b11
  } irq_src_e;
endpackage

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
  import uart_regs_pkg::*;
#(
  parameter int DW = BYTE_W,
  localparam int DIVW = 2 * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [3:0]        ien,
  output logic [DW-1:0]     line_q,
  output logic [4:0]        modem_q,
  output logic [DIVW-1:0]   div_q,
  output logic              fifo_q
);
  logic bank;
  assign bank = line_q[DW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien     <= '0;
      line_q  <= '0;
      modem_q <= '0;
      div_q   <= '0;
      fifo_q  <= 1'b0;
    end else if (wr_en) begin
      unique case (addr)
        A_DATA:  if (bank) div_q[DW-1:0] <= wdata;
        A_IEN:   if (bank) div_q[DIVW-1:DW] <= wdata;
                 else ien <= wdata[3:0];
        A_IDENT: fifo_q  <= wdata[0];
        A_LINE:  line_q  <= wdata;
        A_MODEM: modem_q <= wdata[4:0];
        default: ;
      endcase
    end
  end

  // R3
  div_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_IEN && bank) |=> (div_q[DIVW-1:DW] == $past(wdata) && $stable(ien)));
  // R3
  div_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DATA && bank) |=> (div_q[DW-1:0] == $past(wdata)));
endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
  import uart_regs_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    ien,
  input  logic          line_err,
  input  logic          rx_avail,
  input  logic          tx_empty,
  input  logic          modem_chg,
  input  logic          ident_rd,
  input  logic          hold_wr,
  input  logic          fifo_on,
  input  logic          gate,
  output logic [DW-1:0] ident,
  output logic          irq
);
  logic txe_q, txe_pend, txe_rise;
  logic p_lerr, p_rxd, p_txe, p_mod, any;
  irq_src_e src;

  assign txe_rise = tx_empty & ~txe_q;
  assign p_lerr = ien[2] & line_err;
  assign p_rxd  = ien[0] & rx_avail;
  assign p_txe  = ien[1] & txe_pend;
  assign p_mod  = ien[3] & modem_chg;
  assign any    = p_lerr | p_rxd | p_txe | p_mod;

  always_comb begin
    if (p_lerr)     src = SRC_LERR;
    else if (p_rxd) src = SRC_RXD;
    else if (p_txe) src = SRC_TXE;
    else            src = SRC_MODEM;
  end

  always_comb begin
    ident = '0;
    ident[DW-1:DW-2] = {2{fifo_on}};
    ident[0] = ~any;
    if (any) ident[2:1] = src;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txe_q    <= 1'b0;
      txe_pend <= 1'b0;
      irq      <= 1'b0;
    end else begin
      txe_q <= tx_empty;
      irq   <= any & gate;
      if (txe_rise) txe_pend <= 1'b1;
      else if (hold_wr || (ident_rd && any && src == SRC_TXE)) txe_pend <= 1'b0;
    end
  end

  // R7
  lerr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien[2] && line_err) |-> (ident[3:0] == 4'b0110));
  // R9
  txe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ident_rd && ident[3:0] == 4'b0010 && !txe_rise) |=> !txe_pend);
  // R9
  txe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txe_rise |=> txe_pend);
endmodule

// File: rtl/uart_reg_bank.sv
module uart_reg_bank
  import uart_regs_pkg::*;
#(
  parameter int DW = BYTE_W,
  localparam int DIVW = 2 * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DW-1:0]     rdata,
  input  logic [DW-1:0]     rx_data,
  input  logic [DW-1:0]     line_stat,
  input  logic [DW-1:0]     modem_stat,
  input  logic              line_err,
  input  logic              rx_avail,
  input  logic              tx_empty,
  input  logic              modem_chg,
  output logic [DW-1:0]     tx_data,
  output logic              tx_valid,
  output logic              rx_pop,
  output logic [1:0]        word_len,
  output logic              two_stop,
  output logic [2:0]        parity_sel,
  output logic [DIVW-1:0]   divisor,
  output logic              fifo_en,
  output logic              dtr,
  output logic              rts,
  output logic              irq
);
  logic [3:0]    ien;
  logic [DW-1:0] line_q;
  logic [4:0]    modem_q;
  logic [DW-1:0] ident;
  logic          bank;

  uart_ctrl_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ien(ien), .line_q(line_q), .modem_q(modem_q), .div_q(divisor), .fifo_q(fifo_en)
  );

  assign bank     = line_q[DW-1];
  assign tx_valid = wr_en && addr == A_DATA && !bank;
  assign tx_data  = wdata;
  assign rx_pop   = rd_en && addr == A_DATA && !bank;

  uart_int_ident #(.DW(DW)) u_ident (
    .clk(clk), .rst_n(rst_n), .ien(ien), .line_err(line_err), .rx_avail(rx_avail),
    .tx_empty(tx_empty), .modem_chg(modem_chg),
    .ident_rd(rd_en && addr == A_IDENT), .hold_wr(tx_valid),
    .fifo_on(fifo_en), .gate(modem_q[3]), .ident(ident), .irq(irq)
  );

  assign word_len   = line_q[1:0];
  assign two_stop   = line_q[2];
  assign parity_sel = line_q[5:3];
  assign dtr        = modem_q[0];
  assign rts        = modem_q[1];

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_DATA:  rdata = bank ? divisor[DW-1:0] : rx_data;
      A_IEN:   rdata = bank ? divisor[DIVW-1:DW] : {{(DW-4){1'b0}}, ien};
      A_IDENT: rdata = ident;
      A_LINE:  rdata = line_q;
      A_MODEM: rdata = {{(DW-5){1'b0}}, modem_q};
      A_LSTAT: rdata = line_stat;
      A_MSTAT: rdata = modem_stat;
      default: rdata = '0;
    endcase
  end

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !modem_q[3] |=> !irq);
  // R3
  bank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank |-> (!tx_valid && !rx_pop));
  // R6
  ident_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ident[5:3] == 3'b000);
endmodule

// File: tb/uart_reg_bank_test.sv
module uart_reg_bank_test;
  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rx_data = 8'h5A, line_stat = 8'h61, modem_stat = 8'hB0;
  logic wr_en = 0, rd_en = 0, line_err = 0, rx_avail = 0, tx_empty = 0, modem_chg = 0;
  logic [7:0] rdata, tx_data;
  logic tx_valid, rx_pop, two_stop, fifo_en, dtr, rts, irq;
  logic [1:0] word_len;
  logic [2:0] parity_sel;
  logic [15:0] divisor;
  int checks = 0, errors = 0;
  logic [7:0] rv;
  logic pop_s, txv_s;
  logic [7:0] txd_s;

  always #10 clk = ~clk;

  uart_reg_bank uut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    #5 txv_s = tx_valid; txd_s = tx_data;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk); addr = a; rd_en = 1;
    #5 rv = rdata; pop_s = rx_pop;
    @(negedge clk); rd_en = 0;
  endtask

  function automatic logic [7:0] exp_ident(input logic [3:0] ie, input logic [3:0] c, input logic f);
    logic [7:0] r;
    r = f ? 8'hC0 : 8'h00;
    if (ie[2] && c[2])      r |= 8'h06;
    else if (ie[0] && c[0]) r |= 8'h04;
    else if (ie[1] && c[1]) r |= 8'h02;
    else if (!(ie[3] && c[3])) r |= 8'h01;
    return r;
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check(irq == 0 && dtr == 0 && rts == 0, "R1 pins", {irq, dtr, rts}, 0);
    check(divisor == 0, "R1 divisor", divisor, 0);
    rd(3'd2); check(rv == 8'h01, "R1 ident", rv, 8'h01);
    rd(3'd1); check(rv == 0, "R1 ien", rv, 0);
    rd(3'd3); check(rv == 0, "R1 line", rv, 0);
    rd(3'd4); check(rv == 0, "R1 modem", rv, 0);
    // R2 pass-through and unused address
    rd(3'd5); check(rv == line_stat, "R2 lstat", rv, line_stat);
    rd(3'd6); check(rv == modem_stat, "R2 mstat", rv, modem_stat);
    wr(3'd7, 8'hFF); rd(3'd7); check(rv == 0, "R2 addr7", rv, 0);
    // R4 data path
    rd(3'd0); check(rv == 8'h5A && pop_s, "R4 rx read", {pop_s, rv}, 9'h15A);
    wr(3'd0, 8'hA5); check(txv_s && txd_s == 8'hA5, "R4 tx write", {txv_s, txd_s}, 9'h1A5);
    // R5 R2 line setup sweep
    for (int v = 0; v < 64; v++) begin
      wr(3'd3, 8'(v));
      check(word_len == v[1:0] && two_stop == v[2] && parity_sel == v[5:3], "R5 fields",
            {parity_sel, two_stop, word_len}, v);
      rd(3'd3); check(rv == 8'(v), "R2 line readback", rv, v);
    end
    // R11 R2 modem control sweep
    for (int v = 0; v < 32; v++) begin
      wr(3'd4, 8'(v) | 8'hE0);
      check(dtr == v[0] && rts == v[1], "R11 dtr rts", {rts, dtr}, v & 3);
      rd(3'd4); check(rv == 8'(v), "R2 modem readback", rv, v);
    end
    // R3 divisor banking
    wr(3'd3, 8'h00); wr(3'd1, 8'h05);
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h34); check(!txv_s, "R3 no tx strobe", txv_s, 0);
    wr(3'd1, 8'h12);
    check(divisor == 16'h1234, "R3 divisor", divisor, 16'h1234);
    rd(3'd0); check(rv == 8'h34 && !pop_s, "R3 low read", {pop_s, rv}, 8'h34);
    rd(3'd1); check(rv == 8'h12, "R3 high read", rv, 8'h12);
    wr(3'd3, 8'h03);
    rd(3'd1); check(rv == 8'h05, "R3 ien kept", rv, 8'h05);
    check(divisor == 16'h1234, "R3 divisor kept", divisor, 16'h1234);
    // R8 FIFO mode bits
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h01); rd(3'd2); check(rv == 8'hC1, "R8 fifo on", rv, 8'hC1);
    wr(3'd2, 8'h00); rd(3'd2); check(rv == 8'h01, "R8 fifo off", rv, 8'h01);
    // R6 R7 R10 sweep over enables and conditions
    wr(3'd2, 8'h01); wr(3'd4, 8'h08);
    for (int ie = 0; ie < 16; ie++) begin
      for (int c = 0; c < 16; c++) begin
        wr(3'd1, 8'(ie));
        @(negedge clk);
        rx_avail = c[0]; line_err = c[2]; modem_chg = c[3];
        wr(3'd0, 8'h00);
        tx_empty = 0; @(negedge clk);
        if (c[1]) begin tx_empty = 1; @(negedge clk); end
        @(negedge clk);
        rv = exp_ident(4'(ie), 4'(c), 1'b1);
        check(irq == !rv[0], "R10 irq", irq, !rv[0]);
        rd(3'd2);
        check(rv == exp_ident(4'(ie), 4'(c), 1'b1), "R7 R6 ident", rv, exp_ident(4'(ie), 4'(c), 1'b1));
      end
    end
    // R10 gate off
    rx_avail = 1; line_err = 0; modem_chg = 0; tx_empty = 0;
    wr(3'd1, 8'h01); wr(3'd4, 8'h03); @(negedge clk);
    check(irq == 0, "R10 gated", irq, 0);
    wr(3'd4, 8'h0B); @(negedge clk);
    check(irq == 1, "R10 ungated", irq, 1);
    // R9 transmit-empty read clear and re-arm
    rx_avail = 0; wr(3'd1, 8'h02);
    wr(3'd0, 8'h11); tx_empty = 1; @(negedge clk); @(negedge clk);
    rd(3'd2); check(rv == 8'hC2, "R9 pending", rv, 8'hC2);
    rd(3'd2); check(rv == 8'hC1, "R9 cleared by read", rv, 8'hC1);
    wr(3'd0, 8'h22); tx_empty = 0; @(negedge clk);
    rd(3'd2); check(rv == 8'hC1, "R9 still clear", rv, 8'hC1);
    tx_empty = 1; @(negedge clk);
    rd(3'd2); check(rv == 8'hC2, "R9 re-armed", rv, 8'hC2);
    tx_empty = 0; @(negedge clk); tx_empty = 1; @(negedge clk);
    wr(3'd0, 8'h33);
    rd(3'd2); check(rv == 8'hC1, "R9 cleared by write", rv, 8'hC1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule